// File: doc/BRIEF.md
# Adaptive Break-Before-Make Gate Sequencer

This block is the clocked control core of a synchronous buck half-bridge. It takes a three-level PWM command and produces two gate-enable outputs, one for the high-side switch and one for the low-side switch. It makes sure the two outputs are never high together. The command reaches the block as two window-comparator flags, one above the upper threshold and one below the lower threshold. The dead time between the two switches is not a fixed count. It depends on two sensed flags: the switch node below threshold, and the low-side gate below threshold. All seven inputs pass through two-flop synchronizers before any logic uses them.

A sequencing state machine has six states. S_OFF holds both gates low. S_HS_ON drives the high side. S_WAIT_LG waits for the low-side gate to discharge. S_LS_ON drives the low side. S_WAIT_SW waits for the switch node to fall. S_LS_FORCED drives the low side after the switch-node timeout. The named transitions are as follows:
- "lockout" goes from any state to S_OFF while shutdown, supply lockout or over-temperature is active.
- "resume" leaves S_OFF for S_WAIT_LG or S_WAIT_SW, depending on the command.
- "fall" moves S_HS_ON, or an aborted S_WAIT_LG, to S_WAIT_SW.
- "rise" moves S_LS_ON, S_LS_FORCED, or an aborted S_WAIT_SW, to S_WAIT_LG.
- "lg_clear" goes from S_WAIT_LG to S_HS_ON.
- "sw_clear" goes from S_WAIT_SW to S_LS_ON.
- "sw_timeout" goes from S_WAIT_SW to S_LS_FORCED.

A separate timer detects a tri-state command that has lasted long enough to mean shutdown. A delay line of PROP_DLY flops sits between the state machine's gate requests and the output pins.

Top module: `bbm_gate_seq`

## Requirements
- R1: With the command steady high (pwm_hi_i=1, pwm_lo_i=0), the outputs settle to hs_en_o=1 and ls_en_o=0. With the command steady low (pwm_hi_i=0, pwm_lo_i=1), they settle to hs_en_o=0 and ls_en_o=1.
- R2: When pwm_hi_i equals pwm_lo_i, the command is in the tri-state window. Both flags low, which is what an open input gives, counts as tri-state. If the window lasts more than TRI_HOLD consecutive clock cycles, both outputs go low. A window of TRI_HOLD cycles or fewer leaves the previous command in force, with no output change.
- R3: Shutdown ends as soon as the command leaves the window, and the sequencer resumes toward the new level.
- R4: On a falling command, hs_en_o drops first. ls_en_o rises only after sw_low_i is seen high.
- R5: On a rising command, ls_en_o drops first. hs_en_o rises only after lg_low_i is seen high.
- R6: If sw_low_i stays low for SW_TMO cycles in S_WAIT_SW, ls_en_o is forced high. It stays high, whatever sw_low_i does, until the command goes high.
- R7: While uvlo_i is high, both outputs are held low. Normal operation resumes when uvlo_i clears.
- R8: While boot_uv_i is high, hs_en_o is held low. ls_en_o follows its normal sequence.
- R9: While ot_i is high, both outputs are held low. Normal operation resumes when ot_i clears.
- R10: A command reversal in the middle of a sequence abandons the pending step and restarts break-before-make in the new direction. An aborted fall never raises ls_en_o.
- R11: hs_en_o and ls_en_o are never high in the same cycle.
- R12: An output responds to an input change on the (PROP_DLY+3)th rising edge after the change: two synchronizer stages, one state register and PROP_DLY delay stages.
- R13: Both outputs are low during and immediately after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi_i | input | 1 | Command above the upper window threshold |
| pwm_lo_i | input | 1 | Command below the lower window threshold |
| sw_low_i | input | 1 | Switch node below threshold |
| lg_low_i | input | 1 | Low-side gate voltage below threshold |
| uvlo_i | input | 1 | Main supply lockout active |
| boot_uv_i | input | 1 | Bootstrap supply lockout active |
| ot_i | input | 1 | Over-temperature flag |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Two functions can act in the same cycle.
- Tri-state shutdown and the normal rise sequence meet when a mid-window excursion of exactly TRI_HOLD+1 cycles ends. In that cycle the one-cycle shutdown and the restart of the sequence coincide. The bench drives excursions of TRI_HOLD and TRI_HOLD+1 cycles and samples hs_en_o at every cycle. It must see no drop for the first excursion and at least one drop for the second.
- The switch-node timeout and a command reversal also compete for the same state, S_WAIT_SW. The bench holds the sensed switch node high and reverses the command partway through. It then requires that the low-side enable never rises and that the high side comes back.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_HS_ON,
        S_WAIT_LG,
        S_LS_ON,
        S_WAIT_SW,
        S_LS_FORCED
    } seq_state_t;

    localparam int FLAG_N    = 7;
    localparam int F_PWM_HI  = 0;
    localparam int F_PWM_LO  = 1;
    localparam int F_SW_LOW  = 2;
    localparam int F_LG_LOW  = 3;
    localparam int F_UVLO    = 4;
    localparam int F_BOOT_UV = 5;
    localparam int F_OT      = 6;

    // lockout flags come out of reset asserted so the sequencer stays off
    localparam logic [FLAG_N-1:0] FLAG_RST = 7'b101_0000;

endpackage

// File: rtl/bbm_sync.sv
module bbm_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stg;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= {2{RST_VAL[i]}};
            else        stg <= {stg[0], d[i]};
        end
        assign q[i] = stg[1];
    end

endmodule

// File: rtl/bbm_tri.sv
module bbm_tri #(
    parameter int TRI_HOLD = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s,
    input  logic lo_s,
    output logic cmd_hi,
    output logic shut
);

    localparam int TW = $clog2(TRI_HOLD + 1);

    logic          mid;
    logic          cmd_q;
    logic [TW-1:0] win_cnt;

    assign mid = (hi_s == lo_s);

    // last valid level stays in force while the window is short
    always_comb begin
        if (hi_s && !lo_s)      cmd_hi = 1'b1;
        else if (lo_s && !hi_s) cmd_hi = 1'b0;
        else                    cmd_hi = cmd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= 1'b0;
            win_cnt <= '0;
        end else begin
            cmd_q <= cmd_hi;
            if (!mid)                        win_cnt <= '0;
            else if (win_cnt != TW'(TRI_HOLD)) win_cnt <= win_cnt + 1'b1;
        end
    end

    // released in the very cycle the window is left
    assign shut = mid && (win_cnt == TW'(TRI_HOLD));

endmodule

// File: rtl/bbm_fsm.sv
module bbm_fsm
    import bbm_pkg::*;
#(
    parameter int SW_TMO   = 38,
    parameter int PROP_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_hi,
    input  logic       off_req,
    input  logic       sw_low,
    input  logic       lg_low,
    input  logic       boot_uv,
    output logic       hs_req,
    output logic       ls_req,
    output seq_state_t state_o
);

    localparam int CW = $clog2(SW_TMO + 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] dwell;
    logic          settled;

    // a wait state must outlast the output delay line before the opposite gate is allowed
    assign settled = (dwell >= CW'(PROP_DLY));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_OFF;
            dwell <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)              dwell <= '0;
            else if (dwell != CW'(SW_TMO)) dwell <= dwell + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        if (off_req) begin
            nxt = S_OFF;
        end else begin
            unique case (state)
                S_OFF:       nxt = cmd_hi ? S_WAIT_LG : S_WAIT_SW;
                S_HS_ON:     if (!cmd_hi) nxt = S_WAIT_SW;
                S_WAIT_LG: begin
                    if (!cmd_hi)                nxt = S_WAIT_SW;
                    else if (lg_low && settled) nxt = S_HS_ON;
                end
                S_LS_ON,
                S_LS_FORCED: if (cmd_hi) nxt = S_WAIT_LG;
                S_WAIT_SW: begin
                    if (cmd_hi)                           nxt = S_WAIT_LG;
                    else if (sw_low && settled)           nxt = S_LS_ON;
                    else if (dwell == CW'(SW_TMO - 1))    nxt = S_LS_FORCED;
                end
                default:     nxt = S_OFF;
            endcase
        end
    end

    always_comb begin
        hs_req = 1'b0;
        ls_req = 1'b0;
        unique case (state)
            S_HS_ON:                 hs_req = !boot_uv;
            S_LS_ON, S_LS_FORCED:    ls_req = 1'b1;
            S_OFF, S_WAIT_LG,
            S_WAIT_SW:               ;
            default:                 ;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/bbm_dly.sv
module bbm_dly #(
    parameter int DEPTH = 3,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (DEPTH == 0) begin : g_wire
        assign q = d;
    end else begin : g_pipe
        logic [W-1:0] stg [DEPTH];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
            end else begin
                stg[0] <= d;
                for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
            end
        end
        assign q = stg[DEPTH-1];
    end

endmodule

// File: rtl/bbm_gate_seq.sv
module bbm_gate_seq
    import bbm_pkg::*;
#(
    parameter int TRI_HOLD = 24,
    parameter int SW_TMO   = 38,
    parameter int PROP_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi_i,
    input  logic pwm_lo_i,
    input  logic sw_low_i,
    input  logic lg_low_i,
    input  logic uvlo_i,
    input  logic boot_uv_i,
    input  logic ot_i,
    output logic hs_en_o,
    output logic ls_en_o
);

    logic [FLAG_N-1:0] flg_raw, flg_s;
    logic              cmd_hi, shut, off_req;
    logic              hs_req, ls_req;
    logic [1:0]        gate_q;
    seq_state_t        fsm_state;

    assign flg_raw = {ot_i, boot_uv_i, uvlo_i, lg_low_i, sw_low_i, pwm_lo_i, pwm_hi_i};

    bbm_sync #(.W(FLAG_N), .RST_VAL(FLAG_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flg_raw),
        .q     (flg_s)
    );

    bbm_tri #(.TRI_HOLD(TRI_HOLD)) tri_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_s   (flg_s[F_PWM_HI]),
        .lo_s   (flg_s[F_PWM_LO]),
        .cmd_hi (cmd_hi),
        .shut   (shut)
    );

    assign off_req = shut | flg_s[F_UVLO] | flg_s[F_OT];

    bbm_fsm #(.SW_TMO(SW_TMO), .PROP_DLY(PROP_DLY)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_hi  (cmd_hi),
        .off_req (off_req),
        .sw_low  (flg_s[F_SW_LOW]),
        .lg_low  (flg_s[F_LG_LOW]),
        .boot_uv (flg_s[F_BOOT_UV]),
        .hs_req  (hs_req),
        .ls_req  (ls_req),
        .state_o (fsm_state)
    );

    bbm_dly #(.DEPTH(PROP_DLY), .W(2)) dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hs_req, ls_req}),
        .q     (gate_q)
    );

    assign hs_en_o = gate_q[1];
    assign ls_en_o = gate_q[0];

endmodule

// File: rtl/bbm_gate_seq_chk.sv
module bbm_gate_seq_chk
    import bbm_pkg::*;
#(
    parameter int TRI_HOLD = 24,
    parameter int SW_TMO   = 38,
    parameter int PROP_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_hi_i,
    input  logic       pwm_lo_i,
    input  logic       uvlo_i,
    input  logic       boot_uv_i,
    input  logic       ot_i,
    input  logic       hs_en_o,
    input  logic       ls_en_o,
    input  seq_state_t state
);

    localparam logic [15:0] LOCK_LAT = 16'(PROP_DLY + 4);
    localparam logic [15:0] TRI_LAT  = 16'(TRI_HOLD + PROP_DLY + 6);

    logic [15:0] mid_run, uv_run, boot_run, ot_run, wsw_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_run  <= '0;
            uv_run   <= '0;
            boot_run <= '0;
            ot_run   <= '0;
            wsw_run  <= '0;
        end else begin
            mid_run  <= (pwm_hi_i == pwm_lo_i) ? ((mid_run  == 16'hFFFF) ? mid_run  : mid_run  + 1'b1) : '0;
            uv_run   <= uvlo_i                 ? ((uv_run   == 16'hFFFF) ? uv_run   : uv_run   + 1'b1) : '0;
            boot_run <= boot_uv_i              ? ((boot_run == 16'hFFFF) ? boot_run : boot_run + 1'b1) : '0;
            ot_run   <= ot_i                   ? ((ot_run   == 16'hFFFF) ? ot_run   : ot_run   + 1'b1) : '0;
            wsw_run  <= (state == S_WAIT_SW)   ? ((wsw_run  == 16'hFFFF) ? wsw_run  : wsw_run  + 1'b1) : '0;
        end
    end

    a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o));

    a_r2_tri_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_run > TRI_LAT) |-> (!hs_en_o && !ls_en_o));

    a_r7_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_run > LOCK_LAT) |-> (!hs_en_o && !ls_en_o));

    a_r8_boot_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_run > LOCK_LAT) |-> !hs_en_o);

    a_r9_ot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_run > LOCK_LAT) |-> (!hs_en_o && !ls_en_o));

    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wsw_run <= 16'(SW_TMO));

endmodule

bind bbm_gate_seq bbm_gate_seq_chk #(
    .TRI_HOLD (TRI_HOLD),
    .SW_TMO   (SW_TMO),
    .PROP_DLY (PROP_DLY)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_hi_i  (pwm_hi_i),
    .pwm_lo_i  (pwm_lo_i),
    .uvlo_i    (uvlo_i),
    .boot_uv_i (boot_uv_i),
    .ot_i      (ot_i),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o),
    .state     (fsm_state)
);

// File: tb/bbm_gate_seq_tb.sv
`timescale 1ns/1ps
module bbm_gate_seq_tb_top;

    localparam int TRI_HOLD = 24;
    localparam int SW_TMO   = 38;
    localparam int PROP_DLY = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic pwm_hi, pwm_lo, uvlo, boot_uv, ot;
    logic sw_force, sw_val, lg_force, lg_val;
    logic sw_low, lg_low;
    logic hs_en, ls_en;

    int n_chk  = 0;
    int n_fail = 0;
    int both_hits = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // plant: sensed nodes follow the gates unless a test pins them
    assign sw_low = sw_force ? sw_val : !hs_en;
    assign lg_low = lg_force ? lg_val : !ls_en;

    bbm_gate_seq #(.TRI_HOLD(TRI_HOLD), .SW_TMO(SW_TMO), .PROP_DLY(PROP_DLY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_hi_i  (pwm_hi),
        .pwm_lo_i  (pwm_lo),
        .sw_low_i  (sw_low),
        .lg_low_i  (lg_low),
        .uvlo_i    (uvlo),
        .boot_uv_i (boot_uv),
        .ot_i      (ot),
        .hs_en_o   (hs_en),
        .ls_en_o   (ls_en)
    );

    always @(negedge clk) if (rst_n && hs_en && ls_en) both_hits++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // 1 = high, 0 = low, 2 = tri-state window
    task automatic set_pwm(input int lvl);
        pwm_hi = (lvl == 1);
        pwm_lo = (lvl == 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        set_pwm(1); uvlo = 0; boot_uv = 0; ot = 0;
        sw_force = 0; sw_val = 0; lg_force = 0; lg_val = 0;
        step(3);
        chk("R13 reset hs", hs_en, 0);
        chk("R13 reset ls", ls_en, 0);
        rst_n = 1'b1;
        step(1);
        chk("R13 after reset hs", hs_en, 0);
        chk("R13 after reset ls", ls_en, 0);
    endtask

    task automatic t_steady;
        step(20);
        chk("R1 high hs", hs_en, 1);
        chk("R1 high ls", ls_en, 0);
        set_pwm(0); step(20);
        chk("R1 low hs", hs_en, 0);
        chk("R1 low ls", ls_en, 1);
    endtask

    task automatic t_latency;
        set_pwm(1);
        step(PROP_DLY + 2);
        chk("R12 ls before latency", ls_en, 1);
        step(0);
        repeat (1) @(posedge clk);
        @(negedge clk);
        chk("R12 ls at latency", ls_en, 0);
        step(20);
        chk("R12 hs settles", hs_en, 1);
    endtask

    task automatic t_fall_order;
        sw_force = 1; sw_val = 0;
        set_pwm(0); step(20);
        chk("R4 hs off first", hs_en, 0);
        chk("R4 ls waits for switch node", ls_en, 0);
        sw_force = 0; step(12);
        chk("R4 ls on after switch node", ls_en, 1);
    endtask

    task automatic t_rise_order;
        lg_force = 1; lg_val = 0;
        set_pwm(1); step(20);
        chk("R5 ls off first", ls_en, 0);
        chk("R5 hs waits for low gate", hs_en, 0);
        lg_force = 0; step(15);
        chk("R5 hs on after low gate", hs_en, 1);
    endtask

    task automatic t_timeout;
        sw_force = 1; sw_val = 0;
        set_pwm(0); step(30);
        chk("R6 before timeout ls", ls_en, 0);
        step(30);
        chk("R6 forced ls", ls_en, 1);
        sw_val = 1; step(10);
        sw_val = 0; step(10);
        chk("R6 forced ls held", ls_en, 1);
        chk("R6 forced hs off", hs_en, 0);
        sw_force = 0;
        set_pwm(1); step(20);
        chk("R6 released by rise hs", hs_en, 1);
        chk("R6 released by rise ls", ls_en, 0);
    endtask

    task automatic t_abort;
        bit ls_seen = 0;
        sw_force = 1; sw_val = 0;
        set_pwm(0); step(10);
        set_pwm(1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ls_en) ls_seen = 1;
        end
        sw_force = 0;
        chk("R10 aborted fall no ls", ls_seen, 0);
        chk("R10 restarted rise hs", hs_en, 1);
    endtask

    task automatic t_tri;
        bit hs_drop;
        hs_drop = 0;
        set_pwm(2);
        for (int i = 0; i < TRI_HOLD + 30; i++) begin
            @(negedge clk);
            if (i == TRI_HOLD - 1) set_pwm(1);
            if (!hs_en) hs_drop = 1;
        end
        chk("R2 short window no change", hs_drop, 0);
        hs_drop = 0;
        set_pwm(2);
        for (int i = 0; i < TRI_HOLD + 30; i++) begin
            @(negedge clk);
            if (i == TRI_HOLD) set_pwm(1);
            if (!hs_en) hs_drop = 1;
        end
        chk("R2 window over hold shuts", hs_drop, 1);
        chk("R3 boundary resume hs", hs_en, 1);
        set_pwm(2); step(TRI_HOLD + 20);
        chk("R2 shutdown hs", hs_en, 0);
        chk("R2 shutdown ls", ls_en, 0);
        set_pwm(0); step(15);
        chk("R3 resume low ls", ls_en, 1);
        chk("R3 resume low hs", hs_en, 0);
    endtask

    task automatic t_uvlo;
        set_pwm(1); step(20);
        uvlo = 1; step(10);
        chk("R7 uvlo hs", hs_en, 0);
        chk("R7 uvlo ls", ls_en, 0);
        set_pwm(0); step(15);
        chk("R7 uvlo ls while low", ls_en, 0);
        uvlo = 0; step(15);
        chk("R7 resume ls", ls_en, 1);
    endtask

    task automatic t_boot;
        boot_uv = 1; step(10);
        chk("R8 low side unaffected", ls_en, 1);
        set_pwm(1); step(20);
        chk("R8 hs held", hs_en, 0);
        chk("R8 ls normal off", ls_en, 0);
        boot_uv = 0; step(10);
        chk("R8 hs released", hs_en, 1);
    endtask

    task automatic t_ot;
        set_pwm(0); step(20);
        ot = 1; step(10);
        chk("R9 ot ls", ls_en, 0);
        chk("R9 ot hs", hs_en, 0);
        ot = 0; step(15);
        chk("R9 resume ls", ls_en, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_steady();
        t_latency();
        t_fall_order();
        t_rise_order();
        t_timeout();
        t_abort();
        t_tri();
        t_uvlo();
        t_boot();
        t_ot();
        chk("R11 both high cycles", both_hits, 0);
        finish_run();
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule